// File: doc/BRIEF.md
# Configurable pin-to-matrix port cell

This cell sits between one external pin and one line of an internal switch matrix. A four-bit mode field picks what the cell does: pass the pin into the matrix, drive the pin from the matrix, register either direction on the clock, act as a two-way transceiver, force the pin to a constant, force the matrix line low, or isolate both sides.

Two enable inputs gate the two directions. The input enable gates pin-to-matrix transfer and the output enable gates matrix-to-pin drive. A "used" bit for each direction says whether that enable is honoured or treated as always active. An inversion bit flips the driven pin value, but only in the modes that allow it.

On the pin side the cell drives a value together with a tri-state enable. On the matrix side it drives a value together with a valid flag.

Top module: `pio_cell`

## Requirements
- R1: Mode code 0 (plain input) passes pin_in to mat_out in the same cycle, with mat_valid at 1 and pin_oe at 0.
- R2: Mode code 1 (plain output) drives pin_out with mat_in XOR invert in the same cycle, and pin_oe follows the effective output enable; mat_valid is 0.
- R3: The effective input enable is 1 when ie_used is 0 and equals ie otherwise; the effective output enable is 1 when oe_used is 0 and equals oe otherwise.
- R4: Whenever pin_oe is 0, pin_out reads 0, and whenever mat_valid is 0, mat_out reads 0.
- R5: Mode code 2 (registered input) presents a capture register on mat_out with mat_valid at 1. On each rising clock edge in this mode the register loads pin_in if the effective input enable is 1, and holds its value otherwise.
- R6: Mode code 3 (registered output) loads mat_in into an output register on every rising edge and drives that register on pin_out, so the pin lags the matrix by one cycle. pin_oe follows the effective output enable, and invert has no effect.
- R7: Mode code 4 (transceiver) drives pin_out with mat_in XOR invert under pin_oe = oe. It also drives mat_out with pin_in under mat_valid = ie. Both enables are honoured here whatever the used bits hold.
- R8: Mode codes 5 and 6 drive a constant 0 or 1 on pin_out regardless of mat_in, with pin_oe following the effective output enable and mat_valid at 0.
- R9: Mode code 7, and every code from 9 to 15, hold pin_oe and mat_valid at 0.
- R10: Mode code 8 (matrix forced low) drives mat_out to 0 with mat_valid following the effective input enable, and pin_oe at 0.
- R11: A synchronous reset (rst high at a rising edge) clears both capture registers to 0.
- R12: The two capture registers change only in their own modes: outside mode 2 the input register holds, and outside mode 3 the output register holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the capture registers |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 4 | Function select code |
| ie_used | input | 1 | 1: honour ie; 0: input enable always active |
| oe_used | input | 1 | 1: honour oe; 0: output enable always active |
| ie | input | 1 | Input enable |
| oe | input | 1 | Output enable |
| invert | input | 1 | Invert the driven pin value where allowed |
| pin_in | input | 1 | Value sensed at the pin |
| mat_in | input | 1 | Value on the matrix line |
| pin_out | output | 1 | Value driven to the pin |
| pin_oe | output | 1 | Pin driver enable |
| mat_out | output | 1 | Value driven to the matrix line |
| mat_valid | output | 1 | Matrix-side driver enable |

## Verification
The clocked properties on the registered modes assume that the mode field stays put across the edge they reason about. They therefore accept any cycle in which the mode has moved away.

The stimulus holds each mode for runs of many cycles before it switches, so these properties are exercised often. During those runs the data, enable, used and inversion inputs change freely every cycle. A final stretch then draws every input, the mode included, at random on each cycle.

// File: rtl/pio_cell.sv
module pio_cell (
  input  logic       clk,
  input  logic       rst,
  input  logic [3:0] mode,
  input  logic       ie_used,
  input  logic       oe_used,
  input  logic       ie,
  input  logic       oe,
  input  logic       invert,
  input  logic       pin_in,
  input  logic       mat_in,
  output logic       pin_out,
  output logic       pin_oe,
  output logic       mat_out,
  output logic       mat_valid
);

  localparam logic [3:0] M_IN  = 4'd0;
  localparam logic [3:0] M_OP  = 4'd1;
  localparam logic [3:0] M_RI  = 4'd2;
  localparam logic [3:0] M_RO  = 4'd3;
  localparam logic [3:0] M_BT  = 4'd4;
  localparam logic [3:0] M_PL  = 4'd5;
  localparam logic [3:0] M_PH  = 4'd6;
  localparam logic [3:0] M_AL  = 4'd8;

  logic ie_eff, oe_eff;
  logic ri_q, ro_q;
  logic drv_val, drv_en, mx_val, mx_en;

  assign ie_eff = !ie_used || ie;
  assign oe_eff = !oe_used || oe;

  always_ff @(posedge clk) begin
    if (rst) begin
      ri_q <= 1'b0;
      ro_q <= 1'b0;
    end else begin
      if (mode == M_RI && ie_eff) ri_q <= pin_in;
      if (mode == M_RO)           ro_q <= mat_in;
    end
  end

  always_comb begin
    drv_val = 1'b0;
    drv_en  = 1'b0;
    mx_val  = 1'b0;
    mx_en   = 1'b0;
    case (mode)
      M_IN: begin
        mx_val = pin_in;
        mx_en  = 1'b1;
      end
      M_OP: begin
        drv_val = mat_in ^ invert;
        drv_en  = oe_eff;
      end
      M_RI: begin
        mx_val = ri_q;
        mx_en  = 1'b1;
      end
      M_RO: begin
        drv_val = ro_q;
        drv_en  = oe_eff;
      end
      M_BT: begin
        drv_val = mat_in ^ invert;
        drv_en  = oe;
        mx_val  = pin_in;
        mx_en   = ie;
      end
      M_PL: begin
        drv_val = 1'b0;
        drv_en  = oe_eff;
      end
      M_PH: begin
        drv_val = 1'b1;
        drv_en  = oe_eff;
      end
      M_AL: begin
        mx_val = 1'b0;
        mx_en  = ie_eff;
      end
      default: ;
    endcase
  end

  assign pin_out   = drv_en & drv_val;
  assign pin_oe    = drv_en;
  assign mat_out   = mx_en & mx_val;
  assign mat_valid = mx_en;

endmodule

module pio_cell_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] mode,
  input logic       ie_used,
  input logic       oe_used,
  input logic       ie,
  input logic       oe,
  input logic       invert,
  input logic       pin_in,
  input logic       mat_in,
  input logic       pin_out,
  input logic       pin_oe,
  input logic       mat_out,
  input logic       mat_valid
);

  a_r4_quiet_pin: assert property (@(posedge clk) disable iff (rst)
    !pin_oe |-> !pin_out);

  a_r4_quiet_mat: assert property (@(posedge clk) disable iff (rst)
    !mat_valid |-> !mat_out);

  a_r1_in_pass: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd0) |-> (mat_valid && mat_out == pin_in && !pin_oe));

  a_r9_isolated: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd7 || mode > 4'd8) |-> (!pin_oe && !mat_valid));

  a_r8_force_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd5) |-> (!pin_out && !mat_valid));

  a_r8_force_high: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd6 && pin_oe) |-> pin_out);

  a_r10_mat_low: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd8) |-> (!mat_out && !pin_oe));

  a_r5_capture: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd2 && (!ie_used || ie)) |=> (mode != 4'd2 || mat_out == $past(pin_in)));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd2 && ie_used && !ie) |=> (mode != 4'd2 || $stable(mat_out)));

  a_r6_lag: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd3) |=> (mode != 4'd3 || !pin_oe || pin_out == $past(mat_in)));

  a_r7_gates: assert property (@(posedge clk) disable iff (rst)
    (mode == 4'd4) |-> (pin_oe == oe && mat_valid == ie));

endmodule

bind pio_cell pio_cell_chk chk_i (
  .clk(clk), .rst(rst), .mode(mode), .ie_used(ie_used), .oe_used(oe_used),
  .ie(ie), .oe(oe), .invert(invert), .pin_in(pin_in), .mat_in(mat_in),
  .pin_out(pin_out), .pin_oe(pin_oe), .mat_out(mat_out), .mat_valid(mat_valid)
);

// File: tb/pio_cell_test.sv
module pio_cell_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] mode = 4'd2;
  logic ie_used = 1'b0, oe_used = 1'b0, ie = 1'b0, oe = 1'b0, invert = 1'b0;
  logic pin_in = 1'b0, mat_in = 1'b0;
  logic pin_out, pin_oe, mat_out, mat_valid;

  int compared = 0;
  int mismatched = 0;
  bit done = 1'b0;

  bit m_ri = 1'b0, m_ro = 1'b0;

  pio_cell uut (
    .clk(clk), .rst(rst), .mode(mode), .ie_used(ie_used), .oe_used(oe_used),
    .ie(ie), .oe(oe), .invert(invert), .pin_in(pin_in), .mat_in(mat_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .mat_out(mat_out), .mat_valid(mat_valid)
  );

  always #5 clk = ~clk;

  // Reference register model (R5, R6, R11, R12)
  always @(posedge clk) begin
    if (rst) begin
      m_ri <= 1'b0;
      m_ro <= 1'b0;
    end else begin
      if (mode == 4'd2 && (ie || !ie_used)) m_ri <= pin_in;
      if (mode == 4'd3) m_ro <= mat_in;
    end
  end

  function automatic string tag(input logic [3:0] m);
    if (m == 0) return "R1";
    if (m == 1) return "R2";
    if (m == 2) return "R5";
    if (m == 3) return "R6";
    if (m == 4) return "R7";
    if (m == 5 || m == 6) return "R8";
    if (m == 8) return "R10";
    return "R9";
  endfunction

  task automatic compare(input string req);
    bit e_po, e_poe, e_mo, e_mv, ieff, oeff;
    ieff = ie_used ? ie : 1'b1;   // R3
    oeff = oe_used ? oe : 1'b1;
    e_po = 0; e_poe = 0; e_mo = 0; e_mv = 0;
    if (mode == 0) begin e_mv = 1; e_mo = pin_in; end
    else if (mode == 1) begin e_poe = oeff; e_po = mat_in ^ invert; end
    else if (mode == 2) begin e_mv = 1; e_mo = m_ri; end
    else if (mode == 3) begin e_poe = oeff; e_po = m_ro; end
    else if (mode == 4) begin e_poe = oe; e_po = mat_in ^ invert; e_mv = ie; e_mo = pin_in; end
    else if (mode == 5) begin e_poe = oeff; e_po = 0; end
    else if (mode == 6) begin e_poe = oeff; e_po = 1; end
    else if (mode == 8) begin e_mv = ieff; e_mo = 0; end
    if (!e_poe) e_po = 0;  // R4
    if (!e_mv) e_mo = 0;
    compared++;
    if ({pin_out, pin_oe, mat_out, mat_valid} !== {e_po, e_poe, e_mo, e_mv}) begin
      mismatched++;
      $display("FAIL %s mode=%0d actual po/oe/mo/mv=%b%b%b%b expected=%b%b%b%b",
               req, mode, pin_out, pin_oe, mat_out, mat_valid, e_po, e_poe, e_mo, e_mv);
    end
  endtask

  always @(negedge clk) if (!done) compare(rst ? "R11" : tag(mode));

  task automatic drive_rand(input bit rand_mode);
    @(posedge clk); #2;
    if (rand_mode) mode = 4'($urandom_range(0, 15));
    ie_used = 1'($urandom); oe_used = 1'($urandom);
    ie = 1'($urandom); oe = 1'($urandom); invert = 1'($urandom);
    pin_in = 1'($urandom); mat_in = 1'($urandom);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst = 1'b0;
    @(negedge clk);
    compared++;
    if (mat_out !== 1'b0) begin  // R11: reset state of input register
      mismatched++;
      $display("FAIL R11 reset mat_out actual=%b expected=0", mat_out);
    end
    for (int m = 0; m < 16; m++) begin  // R3 R12 covered by random enables across modes
      @(posedge clk); #2 mode = 4'(m);
      repeat (40) drive_rand(1'b0);
    end
    // R11: load ones then reset in registered modes
    @(posedge clk); #2 mode = 4'd2; ie_used = 0; pin_in = 1;
    @(posedge clk); #2 mode = 4'd3; mat_in = 1; oe_used = 0;
    @(posedge clk); #2 rst = 1;
    @(posedge clk); #2 rst = 0; mode = 4'd3;
    @(posedge clk); #2 mode = 4'd2;
    for (int i = 0; i < 3000; i++) drive_rand(1'b1);
    @(posedge clk); #2 done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #500000;
    mismatched++;
    $display("FAIL watchdog actual=timeout expected=finish");
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule